// File: doc/BRIEF.md
# Register-Mapped 64-Input Interrupt Controller

This block gathers 64 level-sensitive interrupt lines and presents one winning request to the processor. The winner is given as a priority level and a vector number. Software programs the block over a simple bus with 8-bit addresses and 32-bit data. Through that bus it can read the live pending state and program a 64-bit mask, either one 32-bit half at a time or through single-bit set and clear commands. It also gives each source its own priority byte. A source takes part in arbitration only while three things hold: its line is pending, its priority byte is nonzero, and its mask bit is clear.

Among the sources that take part, the highest priority byte wins. When several sources tie on the top priority, the one with the highest source index wins. The level output carries the winning priority byte. The vector output is 64 plus the winning source index, or 24 when nothing is requesting. Software can also read the current vector as an acknowledge value. A force register is reserved in the map. No bus path writes it, so it always reads zero and never adds requests.

Top module: `intc_top`

## Requirements
- R1: After reset the mask reads all ones at 0x08 and 0x0C. Pending (0x00, 0x04) and every priority byte read zero. `cpu_level` is 0 and `cpu_vector` is 24.
- R2: Each pending bit takes the value of its interrupt line at every clock edge. Offset 0x00 reads sources 63..32 (bit 0 of the word is source 32) and 0x04 reads sources 31..0. Writes to 0x00 and 0x04 change nothing.
- R3: The mask is read and written at 0x08 (sources 63..32) and 0x0C (sources 31..0). A write replaces only the addressed half.
- R4: A write to 0x1C with data bit 6 set sets every mask bit. With bit 6 clear it sets only the mask bit of source data[5:0].
- R5: A write to 0x1D with data bit 6 set clears every mask bit. With bit 6 clear it clears only the mask bit of source data[5:0].
- R6: Offset 0x40+n holds the priority byte of source n (data[7:0], read back zero-extended). Writing zero takes the source out of arbitration, and writing any nonzero value lets it take part.
- R7: Among sources that are pending, unmasked and have a nonzero priority, the one with the highest priority byte wins. Ties go to the higher source index. `cpu_level` equals the winner's priority byte and `cpu_vector` equals 64+index. With no eligible source, the level is 0 and the vector is 24.
- R8: A read at 0xE0 returns the current `cpu_vector`, zero-extended.
- R9: The force words at 0x10 and 0x14 read zero. Reads of unlisted offsets return zero. Writes to unlisted offsets (including 0x10, 0x14, 0x80 and above) change no state.
- R10: `bus_rdata` carries the read value in the cycle after a `bus_rd` cycle and is zero otherwise. `cpu_level` and `cpu_vector` change at the clock edge after the register state changes. A new line level therefore appears at the outputs two edges after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the access |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq_in | input | 64 | Level-sensitive interrupt lines, bit n is source n |
| cpu_level | output | 8 | Priority byte of the winning source, 0 when idle |
| cpu_vector | output | 8 | 64 plus winning index, 24 when idle |

## Verification
The bench builds the block with its default parameters: 64 sources, 8-bit priority bytes and 32-bit data. With these values every source index, both mask halves and both ends of the priority byte range can be reached from the bus. That puts within reach ties between source 63 and lower sources, the all-sources mask commands, and the idle vector. A pseudo-random phase mixes priority writes, including zeros, with sparse mask words and line patterns, and compares the winner against a descending-scan model.

// File: rtl/intc_pkg.sv
package intc_pkg;

  localparam int ADDR_W   = 8;
  localparam int DATA_W   = 32;
  localparam int PRIO_W   = 8;
  localparam int VEC_W    = 8;
  localparam int VEC_BASE = 64;
  localparam int VEC_IDLE = 24;

  typedef enum logic [7:0] {
    OFS_PEND_HI  = 8'h00,
    OFS_PEND_LO  = 8'h04,
    OFS_MASK_HI  = 8'h08,
    OFS_MASK_LO  = 8'h0C,
    OFS_FORCE_HI = 8'h10,
    OFS_FORCE_LO = 8'h14,
    OFS_MSET     = 8'h1C,
    OFS_MCLR     = 8'h1D,
    OFS_ACK      = 8'hE0
  } ofs_e;

  // Tie rule: the higher-index contender wins on equal priority.
  function automatic logic upper_wins(input logic lo_v, input logic [PRIO_W-1:0] lo_p,
                                      input logic hi_v, input logic [PRIO_W-1:0] hi_p);
    return hi_v && (!lo_v || (hi_p >= lo_p));
  endfunction

  function automatic logic [VEC_W-1:0] vec_of(input logic valid, input int idx);
    return valid ? VEC_W'(VEC_BASE + idx) : VEC_W'(VEC_IDLE);
  endfunction

endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W,
  parameter int PW   = PRIO_W,
  parameter int VW   = VEC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             wr,
  input  logic             rd,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata,
  input  logic [NSRC-1:0]  irq_in,
  input  logic [VW-1:0]    vec_now,
  output logic [NSRC-1:0]  pend_q,
  output logic [NSRC-1:0]  mask_q,
  output logic [NSRC-1:0]  force_q,
  output logic [NSRC-1:0]  enab_q,
  output logic [NSRC*PW-1:0] prio_flat
);

  localparam int HALF  = NSRC / 2;
  localparam int IDX_W = $clog2(NSRC);
  localparam logic [AW-1:0] PRIO_LO = AW'(64);
  localparam logic [AW-1:0] PRIO_HI = AW'(64 + NSRC - 1);

  logic [PW-1:0] prio_q [NSRC];

  // named decode events
  logic             in_prio;
  logic [IDX_W-1:0] prio_sel;
  logic             wr_prio, wr_mask_hi, wr_mask_lo, wr_mset, wr_mclr;
  logic [NSRC-1:0]  mask_d;
  logic [DW-1:0]    rd_val;

  assign in_prio    = (addr >= PRIO_LO) && (addr <= PRIO_HI);
  assign prio_sel   = IDX_W'(addr - PRIO_LO);
  assign wr_prio    = wr && in_prio;
  assign wr_mask_hi = wr && (addr == OFS_MASK_HI);
  assign wr_mask_lo = wr && (addr == OFS_MASK_LO);
  assign wr_mset    = wr && (addr == OFS_MSET);
  assign wr_mclr    = wr && (addr == OFS_MCLR);

  function automatic logic [NSRC-1:0] mask_cmd(input logic [NSRC-1:0] cur,
                                               input logic set,
                                               input logic all,
                                               input logic [IDX_W-1:0] idx);
    logic [NSRC-1:0] one;
    one = NSRC'(1) << idx;
    if (all) return set ? '1 : '0;
    return set ? (cur | one) : (cur & ~one);
  endfunction

  always_comb begin
    mask_d = mask_q;
    if (wr_mask_hi) mask_d[NSRC-1:HALF] = wdata[HALF-1:0];
    if (wr_mask_lo) mask_d[HALF-1:0]    = wdata[HALF-1:0];
    if (wr_mset)    mask_d = mask_cmd(mask_q, 1'b1, wdata[IDX_W], wdata[IDX_W-1:0]);
    if (wr_mclr)    mask_d = mask_cmd(mask_q, 1'b0, wdata[IDX_W], wdata[IDX_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      mask_q  <= '1;
      force_q <= '0;
    end else begin
      pend_q <= irq_in;
      mask_q <= mask_d;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      enab_q <= '0;
      for (int n = 0; n < NSRC; n++) prio_q[n] <= '0;
    end else if (wr_prio) begin
      prio_q[prio_sel] <= wdata[PW-1:0];
      enab_q[prio_sel] <= |wdata[PW-1:0];
    end
  end

  for (genvar g = 0; g < NSRC; g++) begin : g_flat
    assign prio_flat[g*PW +: PW] = prio_q[g];
  end

  always_comb begin
    rd_val = '0;
    if (in_prio) begin
      rd_val = DW'(prio_q[prio_sel]);
    end else begin
      case (addr)
        OFS_PEND_HI:  rd_val = pend_q[NSRC-1:HALF];
        OFS_PEND_LO:  rd_val = pend_q[HALF-1:0];
        OFS_MASK_HI:  rd_val = mask_q[NSRC-1:HALF];
        OFS_MASK_LO:  rd_val = mask_q[HALF-1:0];
        OFS_FORCE_HI: rd_val = force_q[NSRC-1:HALF];
        OFS_FORCE_LO: rd_val = force_q[HALF-1:0];
        OFS_ACK:      rd_val = DW'(vec_now);
        default:      rd_val = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd ? rd_val : '0;
  end

endmodule

// File: rtl/intc_resolve.sv
module intc_resolve
  import intc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int PW   = PRIO_W,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]    cand,
  input  logic [NSRC*PW-1:0] prio_flat,
  output logic               win_valid,
  output logic [PW-1:0]      win_prio,
  output logic [IDX_W-1:0]   win_idx
);

  // heap-ordered tournament tree: node i has children 2i (lower) and 2i+1 (upper)
  logic             nv [1:2*NSRC-1];
  logic [PW-1:0]    np [1:2*NSRC-1];
  logic [IDX_W-1:0] ni [1:2*NSRC-1];

  for (genvar k = 0; k < NSRC; k++) begin : g_leaf
    assign nv[NSRC+k] = cand[k];
    assign np[NSRC+k] = prio_flat[k*PW +: PW];
    assign ni[NSRC+k] = IDX_W'(k);
  end

  for (genvar i = 1; i < NSRC; i++) begin : g_node
    logic take_hi;
    assign take_hi = upper_wins(nv[2*i], np[2*i], nv[2*i+1], np[2*i+1]);
    assign nv[i]   = nv[2*i] | nv[2*i+1];
    assign np[i]   = take_hi ? np[2*i+1] : np[2*i];
    assign ni[i]   = take_hi ? ni[2*i+1] : ni[2*i];
  end

  assign win_valid = nv[1];
  assign win_prio  = np[1];
  assign win_idx   = ni[1];

endmodule

// File: rtl/intc_present.sv
module intc_present
  import intc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int PW   = PRIO_W,
  parameter int VW   = VEC_W,
  localparam int IDX_W = $clog2(NSRC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             win_valid,
  input  logic [PW-1:0]    win_prio,
  input  logic [IDX_W-1:0] win_idx,
  output logic [PW-1:0]    level,
  output logic [VW-1:0]    vector
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      level  <= '0;
      vector <= VW'(VEC_IDLE);
    end else begin
      level  <= win_valid ? win_prio : '0;
      vector <= vec_of(win_valid, int'(win_idx));
    end
  end

endmodule

// File: rtl/intc_top.sv
module intc_top
  import intc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W,
  parameter int PW   = PRIO_W,
  parameter int VW   = VEC_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_wr,
  input  logic            bus_rd,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NSRC-1:0] irq_in,
  output logic [PW-1:0]   cpu_level,
  output logic [VW-1:0]   cpu_vector
);

  localparam int IDX_W = $clog2(NSRC);

  logic [NSRC-1:0]    pend_w, mask_w, force_w, enab_w, eligible;
  logic [NSRC*PW-1:0] prio_w;
  logic               win_valid;
  logic [PW-1:0]      win_prio;
  logic [IDX_W-1:0]   win_idx;

  intc_regs #(.NSRC(NSRC), .AW(AW), .DW(DW), .PW(PW), .VW(VW)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wr(bus_wr), .rd(bus_rd),
    .wdata(bus_wdata), .rdata(bus_rdata), .irq_in(irq_in), .vec_now(cpu_vector),
    .pend_q(pend_w), .mask_q(mask_w), .force_q(force_w), .enab_q(enab_w),
    .prio_flat(prio_w)
  );

  assign eligible = (pend_w | force_w) & enab_w & ~mask_w;

  intc_resolve #(.NSRC(NSRC), .PW(PW)) u_resolve (
    .cand(eligible), .prio_flat(prio_w),
    .win_valid(win_valid), .win_prio(win_prio), .win_idx(win_idx)
  );

  intc_present #(.NSRC(NSRC), .PW(PW), .VW(VW)) u_present (
    .clk(clk), .rst_n(rst_n), .win_valid(win_valid), .win_prio(win_prio),
    .win_idx(win_idx), .level(cpu_level), .vector(cpu_vector)
  );

endmodule

// File: rtl/intc_chk.sv
module intc_chk
  import intc_pkg::*;
#(
  parameter int NSRC = 64,
  parameter int AW   = ADDR_W,
  parameter int DW   = DATA_W,
  parameter int PW   = PRIO_W,
  parameter int VW   = VEC_W
) (
  input logic            clk,
  input logic            rst_n,
  input logic [AW-1:0]   bus_addr,
  input logic            bus_wr,
  input logic            bus_rd,
  input logic [DW-1:0]   bus_wdata,
  input logic [DW-1:0]   bus_rdata,
  input logic [NSRC-1:0] irq_in,
  input logic [PW-1:0]   cpu_level,
  input logic [VW-1:0]   cpu_vector,
  input logic [NSRC-1:0] pend_q,
  input logic [NSRC-1:0] mask_q,
  input logic [NSRC-1:0] enab_q
);

  localparam int IDX_W = $clog2(NSRC);

  logic live_q;
  always_ff @(posedge clk) live_q <= rst_n;

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (cpu_level == '0 && cpu_vector == VW'(VEC_IDLE) && mask_q == '1));

  // R2
  pend_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    live_q |-> (pend_q == $past(irq_in)));

  // R4
  mask_set_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_MSET && bus_wdata[IDX_W]) |=> (mask_q == '1));

  // R5
  mask_clr_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFS_MCLR && bus_wdata[IDX_W]) |=> (mask_q == '0));

  // R6
  prio_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr[AW-1:IDX_W] == 2'b01 && bus_wdata[PW-1:0] == '0)
      |=> !enab_q[$past(bus_addr[IDX_W-1:0])]);

  // R7
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_level == '0) |-> (cpu_vector == VW'(VEC_IDLE)));

  // R7
  active_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_level != '0) |-> (cpu_vector >= VW'(VEC_BASE)));

  // R8
  ack_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == OFS_ACK) |=> (bus_rdata == DW'($past(cpu_vector))));

  // R10
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> (bus_rdata == '0));

endmodule

bind intc_top intc_chk #(.NSRC(NSRC), .AW(AW), .DW(DW), .PW(PW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
  .cpu_level(cpu_level), .cpu_vector(cpu_vector),
  .pend_q(pend_w), .mask_q(mask_w), .enab_q(enab_w)
);

// File: tb/sim_intc_top.sv
module sim_intc_top;

  localparam int CLK_NS = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [63:0] irq_in = '0;
  logic [7:0]  cpu_level;
  logic [7:0]  cpu_vector;

  always #(CLK_NS/2) clk = ~clk;

  intc_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .cpu_level(cpu_level), .cpu_vector(cpu_vector)
  );

  int nvec = 0;
  int nerr = 0;

  // bench model
  logic [63:0] m_mask = '1;
  logic [63:0] m_pend = '0;
  logic [7:0]  m_prio [64];
  logic [63:0] rng = 64'h9E37_79B9_7F4A_7C15;

  logic [31:0] expq [$];
  string       tagq [$];

  function automatic void model_out(output logic [7:0] lvl, output logic [7:0] vec);
    lvl = 8'd0;
    vec = 8'd24;
    for (int i = 63; i >= 0; i--) begin
      if (m_pend[i] && !m_mask[i] && m_prio[i] != 8'd0 && m_prio[i] > lvl) begin
        lvl = m_prio[i];
        vec = 8'(64 + i);
      end
    end
  endfunction

  task automatic step();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 7);
    rng = rng ^ (rng << 17);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    case (a)
      8'h08: m_mask[63:32] = d;
      8'h0C: m_mask[31:0]  = d;
      8'h1C: if (d[6]) m_mask = '1; else m_mask[d[5:0]] = 1'b1;
      8'h1D: if (d[6]) m_mask = '0; else m_mask[d[5:0]] = 1'b0;
      default: if (a >= 8'h40 && a < 8'h80) m_prio[a - 8'h40] = d[7:0];
    endcase
  endtask

  // driver: queues the expected read word for the monitor
  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    expq.push_back(exp);
    tagq.push_back(tag);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  // monitor: compares the word returned the cycle after each read strobe
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (expq.size() > 0) begin
          logic [31:0] e;
          string t;
          e = expq.pop_front();
          t = tagq.pop_front();
          nvec++;
          if (bus_rdata !== e) begin
            nerr++;
            $display("FAIL %s: rdata got %h expected %h", t, bus_rdata, e);
          end
        end
      end
    end
  end

  task automatic chk_out(input string tag);
    logic [7:0] el, ev;
    model_out(el, ev);
    nvec++;
    if (cpu_level !== el || cpu_vector !== ev) begin
      nerr++;
      $display("FAIL %s: level/vector got %0d/%0d expected %0d/%0d",
               tag, cpu_level, cpu_vector, el, ev);
    end
  endtask

  task automatic chk_raw(input string tag, input logic [7:0] el, input logic [7:0] ev);
    nvec++;
    if (cpu_level !== el || cpu_vector !== ev) begin
      nerr++;
      $display("FAIL %s: level/vector got %0d/%0d expected %0d/%0d",
               tag, cpu_level, cpu_vector, el, ev);
    end
  endtask

  task automatic set_irq(input logic [63:0] v);
    @(negedge clk);
    irq_in = v;
    m_pend = v;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: run got hung expected completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) m_prio[i] = 8'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk_raw("R1 reset outputs", 8'd0, 8'd24);
    rd(8'h08, 32'hFFFF_FFFF, "R1 mask hi");
    rd(8'h0C, 32'hFFFF_FFFF, "R1 mask lo");
    rd(8'h00, 32'h0, "R1 pend hi");
    rd(8'h04, 32'h0, "R1 pend lo");
    rd(8'h7F, 32'h0, "R1 prio 63");
    rd(8'hE0, 32'd24, "R1 ack");

    // R2 pending follows lines; writes ignored
    set_irq(64'h8000_0000_0000_0008);
    settle();
    rd(8'h00, 32'h8000_0000, "R2 pend hi");
    rd(8'h04, 32'h0000_0008, "R2 pend lo");
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h04, 32'hFFFF_FFFF);
    rd(8'h00, 32'h8000_0000, "R2 pend hi after write");
    rd(8'h04, 32'h0000_0008, "R2 pend lo after write");

    // R3 mask halves
    wr(8'h0C, 32'h0000_00F0);
    rd(8'h0C, 32'h0000_00F0, "R3 mask lo");
    rd(8'h08, 32'hFFFF_FFFF, "R3 mask hi untouched");
    wr(8'h08, 32'h1234_5678);
    rd(8'h08, 32'h1234_5678, "R3 mask hi");
    rd(8'h0C, 32'h0000_00F0, "R3 mask lo untouched");

    // R5 / R4 mask commands
    wr(8'h1D, 32'h40);
    rd(8'h08, 32'h0, "R5 clear all hi");
    rd(8'h0C, 32'h0, "R5 clear all lo");
    wr(8'h1C, 32'h05);
    rd(8'h0C, 32'h20, "R4 set bit 5");
    wr(8'h1C, 32'h28);
    rd(8'h08, 32'h100, "R4 set bit 40");
    wr(8'h1D, 32'h05);
    rd(8'h0C, 32'h0, "R5 clear bit 5");
    rd(8'h08, 32'h100, "R5 bit 40 kept");
    wr(8'h1C, 32'h40);
    rd(8'h0C, 32'hFFFF_FFFF, "R4 set all lo");
    rd(8'h08, 32'hFFFF_FFFF, "R4 set all hi");
    wr(8'h1D, 32'h40);
    settle();
    chk_out("R7 no enabled source");

    // R6 / R7 priority and resolution
    wr(8'h43, 32'h05);
    rd(8'h43, 32'h05, "R6 prio readback");
    settle();
    chk_raw("R7 single source", 8'd5, 8'd67);
    wr(8'h7F, 32'h05);
    settle();
    chk_raw("R7 tie to higher index", 8'd5, 8'd127);
    wr(8'h43, 32'h07);
    settle();
    chk_raw("R7 higher priority wins", 8'd7, 8'd67);
    wr(8'h43, 32'h00);
    settle();
    chk_raw("R6 zero priority disables", 8'd5, 8'd127);
    rd(8'hE0, 32'd127, "R8 ack vector");

    // R4 / R5 single mask bit affects arbitration
    wr(8'h1C, 32'd63);
    settle();
    chk_raw("R4 masked source drops", 8'd0, 8'd24);
    rd(8'hE0, 32'd24, "R8 idle ack");
    wr(8'h1D, 32'd63);
    settle();
    chk_raw("R5 unmasked source returns", 8'd5, 8'd127);

    // R10 output timing after a line change
    wr(8'h45, 32'h09);
    settle();
    set_irq(64'h8000_0000_0000_0020);
    @(negedge clk);
    chk_raw("R10 one edge: unchanged", 8'd5, 8'd127);
    @(negedge clk);
    chk_raw("R10 two edges: updated", 8'd9, 8'd69);
    set_irq(64'h0);
    settle();
    chk_raw("R2 lines low idle", 8'd0, 8'd24);
    set_irq(64'h8000_0000_0000_0020);
    settle();

    // R9 unlisted offsets
    rd(8'h10, 32'h0, "R9 force hi");
    rd(8'h14, 32'h0, "R9 force lo");
    rd(8'h20, 32'h0, "R9 unlisted read");
    rd(8'hE1, 32'h0, "R9 unlisted read E1");
    wr(8'h10, 32'hFFFF_FFFF);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h20, 32'hFFFF_FFFF);
    wr(8'h85, 32'h0);
    wr(8'hE0, 32'h0);
    rd(8'h14, 32'h0, "R9 force still zero");
    rd(8'h08, 32'h0, "R9 mask hi unchanged");
    rd(8'h0C, 32'h0, "R9 mask lo unchanged");
    rd(8'h45, 32'h09, "R9 prio unchanged");
    settle();
    chk_raw("R9 outputs unchanged", 8'd9, 8'd69);

    // R7 / R8 pseudo-random mix
    for (int it = 0; it < 40; it++) begin
      for (int k = 0; k < 6; k++) begin
        step();
        wr(8'h40 + {2'b00, rng[5:0]}, {29'd0, rng[10:8]});
      end
      step();
      wr(8'h0C, rng[31:0] & rng[63:32]);
      step();
      wr(8'h08, rng[31:0] & rng[63:32]);
      step();
      set_irq(rng);
      settle();
      chk_out("R7 random pattern");
      begin
        logic [7:0] el, ev;
        model_out(el, ev);
        rd(8'hE0, {24'd0, ev}, "R8 random ack");
      end
    end

    wait (expq.size() == 0);
    @(negedge clk);
    finish_run();
  end

endmodule